// File: doc/BRIEF.md
# Flash Command Sequencer and Status Register

This block interprets the command words that a host writes to a NOR-style flash device and keeps the device's 16-bit status word. It sequences two-write setup/confirm commands and single-write commands, chooses which kind of data a read returns, and keeps per-block lock, lock-down and "programmed since erase" flags. It checks each program or erase against the lock flags and the program-voltage-good input, and it supports suspending an erase, running a program inside that suspend, and suspending that program in turn.

Program, erase and blank-check operations are modelled by countdown timers of parameterised length; the memory array itself is not modelled. Command writes arrive on a valid/ready port. `cmd_ready` is held high, so the block never applies back-pressure and a write is accepted in every cycle where `cmd_valid` is high. Writes that arrive while an operation is running are accepted and then ignored, except for the two commands named in R10. The block (address bits) is the top `BLK_W` bits of `cmd_addr`, and it is taken from the write that starts or confirms a command.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the status word is 16'h0080, the read mode is array (0), the configuration register holds `CFG_RESET`, every block is locked, and no lock-down or programmed flag is set.
- R2: Status bit 7 is ready, bit 6 is erase-suspended, bit 5 is erase/blank-check failure, bit 4 is program failure, bit 3 is program voltage low, bit 2 is program-suspended and bit 1 is locked-block error. Bits 5:4 = 11 mean a sequence error. Bits 15:8 and bit 0 always read 0.
- R3: Writing 00FFh, 0070h, 0090h or 0098h selects the read modes array (0), status (1), identifier (2) or query (3).
- R4: The setup/confirm pairs are 0020h/00D0h (erase), 00BCh/00D0h (blank check), 0060h followed by 0001h (lock), 00D0h (unlock), 002Fh (lock-down) or 0003h (configuration). A setup followed by any other word, or an unknown single word, sets bits 5:4 to 11, returns the sequencer to idle and selects status mode. Suspend (00B0h) and resume (00D0h) with nothing to act on change nothing.
- R5: A configuration confirm loads `cmd_addr[CFG_W-1:0]` into the configuration register. After any setup write the read mode is status. After a lock-class confirm it is array.
- R6: Program (0041h, then one data write) keeps ready low for exactly `PROG_CYC` cycles after the data write. Erase keeps it low for `ERASE_CYC` cycles and blank check for `BLANK_CYC` cycles. Each of these selects status mode.
- R7: A program or erase aimed at a locked block sets bit 1 and does not start.
- R8: A program or erase confirmed while `vpp_ok` is low sets bit 3 and does not start. A running program or erase is aborted, with bit 3 set, in the cycle after `vpp_ok` is seen low.
- R9: Error bits 5, 4, 3 and 1 accumulate and are cleared only by 0050h accepted while ready, or by reset.
- R10: While an operation runs, only 00B0h and 0070h take effect. All other writes, including 0050h and 00FFh, change nothing.
- R11: 00B0h suspends a running erase (bit 6, ready) or a running program (bit 2, ready). A blank check cannot be suspended. During an erase suspend a program may run. 0020h or 00BCh while anything is suspended, and 0041h while a program is suspended, give a sequence error.
- R12: When a program is suspended inside an erase suspend, 00D0h resumes the program first. The next 00D0h resumes the erase.
- R13: A blank check sets bits 5:4 to 10 if the block has completed a program since its last completed erase, and otherwise leaves the status clear.
- R14: Lock-down also locks the block. While `wp_n` is low, unlock has no effect on a locked-down block. While `wp_n` is high, unlock works. Only reset clears lock-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write valid |
| cmd_ready | output | 1 | Always 1: no back-pressure |
| cmd_data | input | 16 | Command or program-data word |
| cmd_addr | input | ADDR_W | Write address; top bits select the block |
| vpp_ok | input | 1 | Program voltage is adequate |
| wp_n | input | 1 | Low: locked-down blocks stay locked |
| status | output | 16 | Status word |
| read_mode | output | 2 | 0 array, 1 status, 2 identifier, 3 query |
| cfg_reg | output | CFG_W | Configuration register |

## Verification
A wrong sequencer state shows at the ports on the next accepted write: either a confirm is taken as a fresh command, or the sequence error never appears, and both are visible in status bits 5:4 and in the read mode one cycle later. Wrong timer or suspend state shows as a ready bit that falls or rises in the wrong cycle, or as a resume that revives the wrong operation. The bench counts busy cycles exactly and reads the full status word after every write. Lock and programmed flags cannot be observed directly, so each flag is probed by issuing a program, erase or blank check to that block and reading bit 1 or bits 5:4.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [15:0] OP_ERASE_SETUP = 16'h0020;
  localparam logic [15:0] OP_BLANK_SETUP = 16'h00BC;
  localparam logic [15:0] OP_LOCK_SETUP  = 16'h0060;
  localparam logic [15:0] OP_CONFIRM     = 16'h00D0;
  localparam logic [15:0] OP_LOCK_CF     = 16'h0001;
  localparam logic [15:0] OP_LDOWN_CF    = 16'h002F;
  localparam logic [15:0] OP_CFG_CF      = 16'h0003;
  localparam logic [15:0] OP_PROG        = 16'h0041;
  localparam logic [15:0] OP_CLEAR       = 16'h0050;
  localparam logic [15:0] OP_RD_ARRAY    = 16'h00FF;
  localparam logic [15:0] OP_RD_STATUS   = 16'h0070;
  localparam logic [15:0] OP_RD_ID       = 16'h0090;
  localparam logic [15:0] OP_RD_QUERY    = 16'h0098;
  localparam logic [15:0] OP_SUSPEND     = 16'h00B0;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID, RM_QUERY} rd_mode_e;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_PROG, ACT_ERASE, ACT_BLANK, ACT_LOCK, ACT_UNLOCK,
    ACT_LDOWN, ACT_CFG, ACT_SEQERR, ACT_CLEAR, ACT_SUSPEND, ACT_RESUME
  } act_e;

  typedef enum logic [2:0] {SQ_IDLE, SQ_ERASE, SQ_BLANK, SQ_LOCK, SQ_PROG} seq_e;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_fire,
  input  logic [15:0] cmd_word,
  input  logic        op_running,
  input  logic        erase_held,
  input  logic        prog_held,
  output act_e        act,
  output logic        rm_we,
  output rd_mode_e    rm_val
);
  seq_e st_q, st_nxt;
  logic any_held;

  assign any_held = erase_held | prog_held;

  always_comb begin
    act    = ACT_NONE;
    rm_we  = 1'b0;
    rm_val = RM_STATUS;
    st_nxt = st_q;
    if (cmd_fire) begin
      if (op_running) begin
        if (cmd_word == OP_SUSPEND) begin
          act   = ACT_SUSPEND;
          rm_we = 1'b1;
        end else if (cmd_word == OP_RD_STATUS) begin
          rm_we = 1'b1;
        end
      end else begin
        rm_we  = 1'b1;
        st_nxt = SQ_IDLE;
        case (st_q)
          SQ_IDLE: begin
            case (cmd_word)
              OP_ERASE_SETUP: begin
                if (any_held) act = ACT_SEQERR;
                else st_nxt = SQ_ERASE;
              end
              OP_BLANK_SETUP: begin
                if (any_held) act = ACT_SEQERR;
                else st_nxt = SQ_BLANK;
              end
              OP_LOCK_SETUP: st_nxt = SQ_LOCK;
              OP_PROG: begin
                if (prog_held) act = ACT_SEQERR;
                else st_nxt = SQ_PROG;
              end
              OP_CLEAR: begin
                act   = ACT_CLEAR;
                rm_we = 1'b0;
              end
              OP_RD_ARRAY:  rm_val = RM_ARRAY;
              OP_RD_STATUS: rm_val = RM_STATUS;
              OP_RD_ID:     rm_val = RM_ID;
              OP_RD_QUERY:  rm_val = RM_QUERY;
              OP_SUSPEND:   rm_we  = 1'b0;
              OP_CONFIRM: begin
                if (any_held) act = ACT_RESUME;
                else rm_we = 1'b0;
              end
              default: act = ACT_SEQERR;
            endcase
          end
          SQ_ERASE: act = (cmd_word == OP_CONFIRM) ? ACT_ERASE : ACT_SEQERR;
          SQ_BLANK: act = (cmd_word == OP_CONFIRM) ? ACT_BLANK : ACT_SEQERR;
          SQ_LOCK: begin
            rm_val = RM_ARRAY;
            case (cmd_word)
              OP_LOCK_CF:  act = ACT_LOCK;
              OP_CONFIRM:  act = ACT_UNLOCK;
              OP_LDOWN_CF: act = ACT_LDOWN;
              OP_CFG_CF:   act = ACT_CFG;
              default: begin
                act    = ACT_SEQERR;
                rm_val = RM_STATUS;
              end
            endcase
          end
          SQ_PROG: act = ACT_PROG;
          default: act = ACT_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_nxt;
  end
endmodule

// File: rtl/flash_countdown.sv
module flash_countdown #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             kill,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (kill)                  cnt_q <= '0;
    else if (en && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BLK_W-1:0]   cmd_blk,
  input  logic               do_lock,
  input  logic               do_unlock,
  input  logic               do_ldown,
  input  logic               wp_n,
  input  logic [BLK_W-1:0]   mark_blk,
  input  logic               mark_dirty,
  input  logic [BLK_W-1:0]   clr_blk,
  input  logic               clr_dirty,
  output logic [NUM_BLK-1:0] locked,
  output logic [NUM_BLK-1:0] dirty
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic lk_q, dn_q, dt_q, hit;
    assign hit       = (cmd_blk == BLK_W'(g));
    assign locked[g] = lk_q;
    assign dirty[g]  = dt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lk_q <= 1'b1;
        dn_q <= 1'b0;
        dt_q <= 1'b0;
      end else begin
        if (hit && (do_lock || do_ldown))
          lk_q <= 1'b1;
        else if (hit && do_unlock && !(dn_q && !wp_n))
          lk_q <= 1'b0;
        if (hit && do_ldown)
          dn_q <= 1'b1;
        if (mark_dirty && mark_blk == BLK_W'(g))
          dt_q <= 1'b1;
        else if (clr_dirty && clr_blk == BLK_W'(g))
          dt_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          CFG_W     = 16,
  parameter int          NUM_BLK   = 8,
  parameter int          PROG_CYC  = 4,
  parameter int          ERASE_CYC = 12,
  parameter int          BLANK_CYC = 6,
  parameter logic [15:0] CFG_RESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              vpp_ok,
  input  logic              wp_n,
  output logic [15:0]       status,
  output logic [1:0]        read_mode,
  output logic [CFG_W-1:0]  cfg_reg
);
  localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int MAX_A   = (PROG_CYC > BLANK_CYC) ? PROG_CYC : BLANK_CYC;
  localparam int MAX_CYC = (ERASE_CYC > MAX_A) ? ERASE_CYC : MAX_A;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  act_e             act;
  logic             rm_we;
  rd_mode_e         rm_val, rm_q;
  logic [BLK_W-1:0] blk, prog_blk_q, long_blk_q;
  logic [NUM_BLK-1:0] locked, dirty;
  logic prog_act_q, prog_susp_q, long_act_q, long_susp_q, long_blank_q;
  logic e1_q, e3_q, e4_q, e5_q;
  logic prog_run, long_run, running;
  logic alter, alter_ok, start_prog, start_erase, start_blank;
  logic abort_prog, abort_long, done_p, done_l, prog_done, long_done;
  logic [CFG_W-1:0] cfg_q;

  assign cmd_ready = 1'b1;
  assign blk       = cmd_addr[ADDR_W-1 -: BLK_W];

  assign prog_run = prog_act_q & ~prog_susp_q;
  assign long_run = long_act_q & ~long_susp_q;
  assign running  = prog_run | long_run;

  flash_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_fire   (cmd_valid),
    .cmd_word   (cmd_data),
    .op_running (running),
    .erase_held (long_susp_q),
    .prog_held  (prog_susp_q),
    .act        (act),
    .rm_we      (rm_we),
    .rm_val     (rm_val)
  );

  assign alter       = (act == ACT_PROG) || (act == ACT_ERASE);
  assign alter_ok    = !locked[blk] && vpp_ok;
  assign start_prog  = (act == ACT_PROG)  && alter_ok;
  assign start_erase = (act == ACT_ERASE) && alter_ok;
  assign start_blank = (act == ACT_BLANK);
  assign abort_prog  = prog_run && !vpp_ok;
  assign abort_long  = long_run && !long_blank_q && !vpp_ok;
  assign prog_done   = done_p && !abort_prog;
  assign long_done   = done_l && !abort_long;

  flash_countdown #(.CNT_W(CNT_W)) u_prog_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_prog),
    .load_val (CNT_W'(PROG_CYC)),
    .en       (prog_run),
    .kill     (abort_prog),
    .done     (done_p)
  );

  flash_countdown #(.CNT_W(CNT_W)) u_long_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_erase | start_blank),
    .load_val (start_blank ? CNT_W'(BLANK_CYC) : CNT_W'(ERASE_CYC)),
    .en       (long_run),
    .kill     (abort_long),
    .done     (done_l)
  );

  flash_lock_bank #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_locks (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_blk    (blk),
    .do_lock    (act == ACT_LOCK),
    .do_unlock  (act == ACT_UNLOCK),
    .do_ldown   (act == ACT_LDOWN),
    .wp_n       (wp_n),
    .mark_blk   (prog_blk_q),
    .mark_dirty (prog_done),
    .clr_blk    (long_blk_q),
    .clr_dirty  (long_done && !long_blank_q),
    .locked     (locked),
    .dirty      (dirty)
  );

  // operation tracking: one program slot and one erase/blank slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_act_q   <= 1'b0;
      prog_susp_q  <= 1'b0;
      long_act_q   <= 1'b0;
      long_susp_q  <= 1'b0;
      long_blank_q <= 1'b0;
      prog_blk_q   <= '0;
      long_blk_q   <= '0;
    end else begin
      if (start_prog) begin
        prog_act_q <= 1'b1;
        prog_blk_q <= blk;
      end else if (prog_done || abort_prog) begin
        prog_act_q <= 1'b0;
      end
      if (act == ACT_SUSPEND && prog_run)
        prog_susp_q <= 1'b1;
      else if (act == ACT_RESUME && prog_susp_q)
        prog_susp_q <= 1'b0;

      if (start_erase || start_blank) begin
        long_act_q   <= 1'b1;
        long_blank_q <= start_blank;
        long_blk_q   <= blk;
      end else if (long_done || abort_long) begin
        long_act_q <= 1'b0;
      end
      if (act == ACT_SUSPEND && !prog_run && long_run && !long_blank_q)
        long_susp_q <= 1'b1;
      else if (act == ACT_RESUME && !prog_susp_q && !prog_act_q && long_susp_q)
        long_susp_q <= 1'b0;
    end
  end

  // sticky error bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_q <= 1'b0;
      e3_q <= 1'b0;
      e4_q <= 1'b0;
      e5_q <= 1'b0;
    end else if (act == ACT_CLEAR) begin
      e1_q <= 1'b0;
      e3_q <= 1'b0;
      e4_q <= 1'b0;
      e5_q <= 1'b0;
    end else begin
      if (alter && locked[blk])                         e1_q <= 1'b1;
      if ((alter && !vpp_ok) || abort_prog || abort_long) e3_q <= 1'b1;
      if (act == ACT_SEQERR) begin
        e4_q <= 1'b1;
        e5_q <= 1'b1;
      end
      if (long_done && long_blank_q && dirty[long_blk_q]) e5_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rm_q  <= RM_ARRAY;
      cfg_q <= CFG_RESET[CFG_W-1:0];
    end else begin
      if (rm_we)           rm_q  <= rm_val;
      if (act == ACT_CFG)  cfg_q <= cmd_addr[CFG_W-1:0];
    end
  end

  assign status    = {8'h00, ~running, long_susp_q, e5_q, e4_q, e3_q,
                      prog_susp_q, e1_q, 1'b0};
  assign read_mode = rm_q;
  assign cfg_reg   = cfg_q;
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_data,
  input logic [15:0] status,
  input logic [1:0]  read_mode
);
  localparam logic [15:0] ERR_MASK = 16'h003A;
  logic clr_take;
  assign clr_take = cmd_valid && (cmd_data == 16'h0050) && status[7];

  a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15:8] == 8'h00) && !status[0]);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(status & ERR_MASK)) && !clr_take) |=>
      ((status & $past(status & ERR_MASK)) == $past(status & ERR_MASK)));

  a_r11_prog_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[7]);

  a_r10_busy_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> (read_mode == 2'd1));

  a_r6_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(cmd_valid));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_data  (cmd_data),
  .status    (status),
  .read_mode (read_mode)
);

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;
  localparam int PROG_CYC  = 4;
  localparam int ERASE_CYC = 12;
  localparam int BLANK_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [15:0] cmd_addr = '0;
  logic        vpp_ok = 1'b1;
  logic        wp_n = 1'b0;
  logic [15:0] status;
  logic [1:0]  read_mode;
  logic [15:0] cfg_reg;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_fsm #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                  .BLANK_CYC(BLANK_CYC), .CFG_RESET(16'hFFFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_addr(cmd_addr), .vpp_ok(vpp_ok), .wp_n(wp_n),
    .status(status), .read_mode(read_mode), .cfg_reg(cfg_reg));

  // {data, addr, expected status, expected mode}
  localparam int NV = 19;
  localparam logic [49:0] VEC [NV] = '{
    {16'h0070, 16'h0000, 16'h0080, 2'd1},
    {16'h0090, 16'h0000, 16'h0080, 2'd2},
    {16'h0098, 16'h0000, 16'h0080, 2'd3},
    {16'h00FF, 16'h0000, 16'h0080, 2'd0},
    {16'h0060, 16'h0000, 16'h0080, 2'd1},
    {16'h00D0, 16'h0000, 16'h0080, 2'd0},
    {16'h0060, 16'h0000, 16'h0080, 2'd1},
    {16'h0003, 16'h1234, 16'h0080, 2'd0},
    {16'h0020, 16'h0000, 16'h0080, 2'd1},
    {16'h00FF, 16'h0000, 16'h00B0, 2'd1},
    {16'h0050, 16'h0000, 16'h0080, 2'd1},
    {16'h0077, 16'h0000, 16'h00B0, 2'd1},
    {16'h0050, 16'h0000, 16'h0080, 2'd1},
    {16'h0060, 16'h0000, 16'h0080, 2'd1},
    {16'h0005, 16'h0000, 16'h00B0, 2'd1},
    {16'h0050, 16'h0000, 16'h0080, 2'd1},
    {16'h00B0, 16'h0000, 16'h0080, 2'd1},
    {16'h00D0, 16'h0000, 16'h0080, 2'd1},
    {16'h0090, 16'h0000, 16'h0080, 2'd2}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = d;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!status[7] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    chk("R1 reset status", status, 16'h0080);
    chk("R1 reset mode", {14'd0, read_mode}, 16'd0);
    chk("R1 reset cfg", cfg_reg, 16'hFFFF);
    chk("R1 ready held", {15'd0, cmd_ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][49:34], VEC[i][33:18]);
      chk($sformatf("R3/R4 vec %0d status", i), status, VEC[i][17:2]);
      chk($sformatf("R3/R4 vec %0d mode", i), {14'd0, read_mode}, {14'd0, VEC[i][1:0]});
    end
    chk("R5 cfg from address", cfg_reg, 16'h1234);

    // R6 program timing on block 1
    wr(16'h0060, 16'h2000); wr(16'h00D0, 16'h2000);
    wr(16'h0041, 16'h0000); wr(16'hA5A5, 16'h2000);
    chk("R6 program busy", status, 16'h0000);
    chk("R6 program mode", {14'd0, read_mode}, 16'd1);
    wait_ready(n);
    chk("R6 program cycles", 16'(n), 16'(PROG_CYC));
    chk("R6 program done", status, 16'h0080);

    // R7 locked block 2
    wr(16'h0041, 16'h0000); wr(16'h1111, 16'h4000);
    chk("R7 locked program", status, 16'h0082);
    wr(16'h0020, 16'h0000); wr(16'h00D0, 16'h4000);
    chk("R7 locked erase", status, 16'h0082);
    wr(16'h0050, 16'h0000);
    chk("R9 clear", status, 16'h0080);

    // R10 busy ignores writes, R9 accumulate
    wr(16'h0077, 16'h0000);
    wr(16'h0041, 16'h0000); wr(16'h2222, 16'h2000);
    chk("R9 accumulate while busy", status, 16'h0030);
    wr(16'h0050, 16'h0000);
    chk("R10 clear ignored busy", status & 16'h00FF, 16'h0030 & {8'h00, 8'hFF});
    wr(16'h00FF, 16'h0000);
    chk("R10 array ignored busy", {14'd0, read_mode}, 16'd1);
    wait_ready(n);
    chk("R9 errors kept", status, 16'h00B0);
    wr(16'h0050, 16'h0000);

    // R13 blank check on programmed block; R11 not suspendable
    wr(16'h00BC, 16'h0000); wr(16'h00D0, 16'h2000);
    wr(16'h00B0, 16'h0000);
    chk("R11 blank not suspended", status, 16'h0000);
    wait_ready(n);
    chk("R13 blank fail", status, 16'h00A0);
    wr(16'h0050, 16'h0000);

    // R8 voltage
    vpp_ok = 1'b0;
    wr(16'h0020, 16'h0000); wr(16'h00D0, 16'h2000);
    chk("R8 vpp low at start", status, 16'h0088);
    wr(16'h0050, 16'h0000);
    vpp_ok = 1'b1;
    wr(16'h0041, 16'h0000); wr(16'h3333, 16'h2000);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R8 vpp drop abort", status, 16'h0088);
    vpp_ok = 1'b1;
    wr(16'h0050, 16'h0000);

    // R6 erase timing, R13 clean after erase
    wr(16'h0020, 16'h0000); wr(16'h00D0, 16'h2000);
    wait_ready(n);
    chk("R6 erase cycles", 16'(n), 16'(ERASE_CYC));
    wr(16'h00BC, 16'h0000); wr(16'h00D0, 16'h2000);
    wait_ready(n);
    chk("R6 blank cycles", 16'(n), 16'(BLANK_CYC));
    chk("R13 blank pass", status, 16'h0080);

    // R11/R12 nested suspend
    wr(16'h0020, 16'h0000); wr(16'h00D0, 16'h2000);
    wr(16'h00B0, 16'h0000);
    chk("R11 erase suspended", status, 16'h00C0);
    wr(16'h0020, 16'h0000);
    chk("R11 erase in suspend", status, 16'h00F0);
    wr(16'h0050, 16'h0000);
    wr(16'h0041, 16'h0000); wr(16'h4444, 16'h0000);
    chk("R11 nested program", status, 16'h0040);
    wr(16'h00B0, 16'h0000);
    chk("R11 program suspended", status, 16'h00C4);
    wr(16'h0041, 16'h0000);
    chk("R11 program in suspend", status, 16'h00F4);
    wr(16'h0050, 16'h0000);
    chk("R9 clear in suspend", status, 16'h00C4);
    wr(16'h00D0, 16'h0000);
    chk("R12 program first", status, 16'h0040);
    wait_ready(n);
    chk("R12 back to erase suspend", status, 16'h00C0);
    wr(16'h00D0, 16'h0000);
    chk("R12 erase resumed", status, 16'h0000);
    wait_ready(n);
    chk("R12 erase done", status, 16'h0080);

    // R14 lock-down
    wp_n = 1'b0;
    wr(16'h0060, 16'h0000); wr(16'h002F, 16'h6000);
    chk("R14 lockdown mode", {14'd0, read_mode}, 16'd0);
    wr(16'h0060, 16'h0000); wr(16'h00D0, 16'h6000);
    wr(16'h0041, 16'h0000); wr(16'h5555, 16'h6000);
    chk("R14 unlock blocked", status, 16'h0082);
    wr(16'h0050, 16'h0000);
    wp_n = 1'b1;
    wr(16'h0060, 16'h0000); wr(16'h00D0, 16'h6000);
    wr(16'h0041, 16'h0000); wr(16'h5555, 16'h6000);
    chk("R14 unlock with wp high", status, 16'h0000);
    wait_ready(n);
    wp_n = 1'b0;
    wr(16'h0060, 16'h0000); wr(16'h0001, 16'h0000);
    wr(16'h0041, 16'h0000); wr(16'h6666, 16'h0000);
    chk("R7 relocked block", status, 16'h0082);

    // R1 after reset: locks back, errors cleared
    do_reset();
    chk("R1 reset clears", status, 16'h0080);
    chk("R1 reset cfg again", cfg_reg, 16'hFFFF);
    wr(16'h0041, 16'h0000); wr(16'h7777, 16'h2000);
    chk("R1 blocks locked", status, 16'h0082);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule